// File: doc/BRIEF.md
# Scan Isolation Wrapper with Three-Lane Test Rail

This block surrounds an embedded logic core so that the core can be scan-tested apart from the logic around it. A 3-bit serial test rail enters and leaves the wrapper, and each rail lane carries its own chain. A lane is built from three parts: boundary cells on the core's combinational inputs, the core's own internal scan chain, and boundary cells on the core's combinational outputs. Each lane also has a one-flop bypass path.

A 2-bit mode input picks one of four behaviours: functional, internal test, external test or lane bypass. A small control unit decodes the mode and produces the core's scan enable. It also gates the dedicated test clock that reaches the core, so that the core's chains receive edges only during internal test.

Negative-edge retiming stages sit where a lane enters and leaves the core's chain. They absorb clock skew between the wrapper and the core and add no shift cycle. Each boundary cell has a shift flop and a hold register. The hold register freezes the value the cell drives while new data is shifted in.

Top module: `core_test_wrapper`

## Requirements
- R1: With mode 2'b00 (functional), core_in equals func_in, func_out equals core_out, and rail_out is all zeros.
- R2: core_tck shows rising edges only while mode is 2'b01 (internal test). In modes 2'b00, 2'b10 and 2'b11 it stays low.
- R3: core_se follows shift_en in mode 2'b01 and is 0 in every other mode.
- R4: In mode 2'b11 (bypass), each rail_out bit equals the matching rail_in bit from one tck rising edge earlier.
- R5: In mode 2'b10 (external test), with shift_en high, each lane is IN_PER_RAIL input cells followed by OUT_PER_RAIL output cells. A bit driven on rail_in appears on rail_out after exactly IN_PER_RAIL+OUT_PER_RAIL rising edges (4 by default).
- R6: In mode 2'b01, with shift_en high, each lane runs through the input cells, then core_si[i]/core_so[i] through the core chain, then the output cells. The delay is IN_PER_RAIL + core chain length + OUT_PER_RAIL edges, and the retiming stages add no cycle.
- R7: On a capture edge (shift_en low in mode 01 or 10), every hold register loads its cell's shift flop. While shifting, the hold registers keep their value. In mode 01, core_in[i*IN_PER_RAIL+c] is the hold of input cell c of lane i. In mode 10, func_out[i*OUT_PER_RAIL+c] is the hold of output cell c. Cell 0 of a segment is nearest to the rail input.
- R8: On a capture edge, input cells load func_in and output cells load core_out. The last output cell (OUT_PER_RAIL-1) feeds rail_out, so its captured value is visible first.
- R9: rst_n low asynchronously clears every wrapper flop. The release is resynchronized to tck over two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Dedicated test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 functional, 01 internal test, 10 external test, 11 bypass |
| shift_en | input | 1 | High shifts the chains; low captures and updates |
| rail_in | input | RAIL_W | Serial test-rail inputs, one per lane |
| rail_out | output | RAIL_W | Serial test-rail outputs, one per lane |
| func_in | input | RAIL_W*IN_PER_RAIL | Combinational signals arriving from neighbouring logic |
| core_in | output | RAIL_W*IN_PER_RAIL | Signals presented to the core's combinational inputs |
| core_out | input | RAIL_W*OUT_PER_RAIL | Core's combinational outputs |
| func_out | output | RAIL_W*OUT_PER_RAIL | Signals presented to neighbouring logic |
| core_tck | output | 1 | Gated test clock for the core's scan flops |
| core_se | output | 1 | Scan enable for the core's chains |
| core_si | output | RAIL_W | Serial data into each core scan chain |
| core_so | input | RAIL_W | Serial data out of each core scan chain |

## Verification
Shift results are due a fixed number of rising edges after the bit is driven: 1 in bypass, 4 in external test, and 9 in internal test with the bench's 5-flop core chain. The scoreboard counts edges from the first driven bit and pops an expected vector only once that count reaches the lane length. Before that point it expects the flushed zeros, so a lane that is one flop short or long is caught. Capture and update results are due on the first edge with shift_en low, and the shifted-out captures follow one per edge. Inputs change 1 ns after a rising edge. Direct checks read the outputs at that moment, and the scoreboard reads them on the falling edge.

// File: rtl/ctw_pkg.sv
package ctw_pkg;
  typedef enum logic [1:0] {
    CTW_FUNC   = 2'b00,
    CTW_INTEST = 2'b01,
    CTW_EXTEST = 2'b10,
    CTW_BYPASS = 2'b11
  } ctw_mode_e;
endpackage

// File: rtl/ctw_ctrl.sv
module ctw_ctrl
  import ctw_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       shift_en,
  output logic       rst_sync_n,
  output logic       test_act,
  output logic       sel_int,
  output logic       sel_ext,
  output logic       sel_byp,
  output logic       core_se,
  output logic       core_tck
);
  ctw_mode_e  mode_e;
  logic [1:0] rst_q;
  logic       gate_en;

  assign mode_e = ctw_mode_e'(mode);

  // release of reset is resynchronized to the test clock
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  always_comb begin
    sel_int  = (mode_e == CTW_INTEST);
    sel_ext  = (mode_e == CTW_EXTEST);
    sel_byp  = (mode_e == CTW_BYPASS);
    test_act = sel_int | sel_ext;
    core_se  = sel_int & shift_en;
  end

  // glitch-free gate: enable only changes while the clock is low
  always_latch begin
    if (!tck) gate_en = sel_int;
  end
  assign core_tck = tck & gate_en;

  p_gate_r2: assert property (@(posedge tck) disable iff (!rst_sync_n)
    (mode != 2'b01 && $stable(mode)) |-> !gate_en)
    else $error("core test clock enabled outside internal test");
endmodule

// File: rtl/ctw_cell.sv
module ctw_cell (
  input  logic tck,
  input  logic rst_n,
  input  logic en,
  input  logic shift,
  input  logic si,
  input  logic cap_d,
  output logic sf_q,
  output logic hold_q
);
  logic sf_d, hold_d;

  always_comb begin
    sf_d   = sf_q;
    hold_d = hold_q;
    if (en) begin
      if (shift) begin
        sf_d = si;
      end else begin
        sf_d   = cap_d;
        hold_d = sf_q;
      end
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sf_q   <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      sf_q   <= sf_d;
      hold_q <= hold_d;
    end
  end

  p_cell_shift_r5: assert property (@(posedge tck) disable iff (!rst_n)
    (en && shift) |=> (sf_q == $past(si)))
    else $error("cell did not shift serial input");
  p_hold_frozen_r7: assert property (@(posedge tck) disable iff (!rst_n)
    (en && shift) |=> $stable(hold_q))
    else $error("hold register moved during shift");
  p_capture_r8: assert property (@(posedge tck) disable iff (!rst_n)
    (en && !shift) |=> (sf_q == $past(cap_d) && hold_q == $past(sf_q)))
    else $error("capture/update mismatch");
endmodule

// File: rtl/ctw_rail_chain.sv
module ctw_rail_chain #(
  parameter int IPC = 2,
  parameter int OPC = 2
) (
  input  logic           tck,
  input  logic           rst_n,
  input  logic           test_act,
  input  logic           sel_int,
  input  logic           sel_ext,
  input  logic           sel_byp,
  input  logic           shift,
  input  logic           rail_si,
  output logic           rail_so,
  input  logic [IPC-1:0] func_in,
  output logic [IPC-1:0] core_in,
  input  logic [OPC-1:0] core_out,
  output logic [OPC-1:0] func_out,
  output logic           core_si,
  input  logic           core_so
);
  logic [IPC-1:0] in_sf, in_hold;
  logic [OPC-1:0] out_sf, out_hold;
  logic           out_head;
  logic           lk_in_q, lk_out_q;
  logic           byp_q, byp_d;

  for (genvar c = 0; c < IPC; c++) begin : g_in
    logic si_c;
    if (c == 0) begin : g_head
      assign si_c = rail_si;
    end else begin : g_link
      assign si_c = in_sf[c-1];
    end
    ctw_cell u_cell (
      .tck(tck), .rst_n(rst_n), .en(test_act), .shift(shift),
      .si(si_c), .cap_d(func_in[c]), .sf_q(in_sf[c]), .hold_q(in_hold[c])
    );
  end

  // internal test routes through the core chain, external test skips it
  assign out_head = sel_int ? lk_out_q : in_sf[IPC-1];

  for (genvar c = 0; c < OPC; c++) begin : g_out
    logic si_c;
    if (c == 0) begin : g_head
      assign si_c = out_head;
    end else begin : g_link
      assign si_c = out_sf[c-1];
    end
    ctw_cell u_cell (
      .tck(tck), .rst_n(rst_n), .en(test_act), .shift(shift),
      .si(si_c), .cap_d(core_out[c]), .sf_q(out_sf[c]), .hold_q(out_hold[c])
    );
  end

  // anti-skew retiming on the falling edge, both directions
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      lk_in_q  <= 1'b0;
      lk_out_q <= 1'b0;
    end else if (sel_int) begin
      lk_in_q  <= in_sf[IPC-1];
      lk_out_q <= core_so;
    end
  end
  assign core_si = lk_in_q;

  assign byp_d = sel_byp ? rail_si : byp_q;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) byp_q <= 1'b0;
    else        byp_q <= byp_d;
  end

  always_comb begin
    if (sel_byp)       rail_so = byp_q;
    else if (test_act) rail_so = out_sf[OPC-1];
    else               rail_so = 1'b0;
    core_in  = sel_int ? in_hold  : func_in;
    func_out = sel_ext ? out_hold : core_out;
  end
endmodule

// File: rtl/core_test_wrapper.sv
module core_test_wrapper
  import ctw_pkg::*;
#(
  parameter int RAIL_W       = 3,
  parameter int IN_PER_RAIL  = 2,
  parameter int OUT_PER_RAIL = 2
) (
  input  logic                             tck,
  input  logic                             rst_n,
  input  logic [1:0]                       mode,
  input  logic                             shift_en,
  input  logic [RAIL_W-1:0]                rail_in,
  output logic [RAIL_W-1:0]                rail_out,
  input  logic [RAIL_W*IN_PER_RAIL-1:0]    func_in,
  output logic [RAIL_W*IN_PER_RAIL-1:0]    core_in,
  input  logic [RAIL_W*OUT_PER_RAIL-1:0]   core_out,
  output logic [RAIL_W*OUT_PER_RAIL-1:0]   func_out,
  output logic                             core_tck,
  output logic                             core_se,
  output logic [RAIL_W-1:0]                core_si,
  input  logic [RAIL_W-1:0]                core_so
);
  localparam int IPC = IN_PER_RAIL;
  localparam int OPC = OUT_PER_RAIL;

  logic rst_sync_n, test_act, sel_int, sel_ext, sel_byp;

  ctw_ctrl u_ctrl (
    .tck(tck), .rst_n(rst_n), .mode(mode), .shift_en(shift_en),
    .rst_sync_n(rst_sync_n), .test_act(test_act), .sel_int(sel_int),
    .sel_ext(sel_ext), .sel_byp(sel_byp), .core_se(core_se), .core_tck(core_tck)
  );

  for (genvar i = 0; i < RAIL_W; i++) begin : g_lane
    ctw_rail_chain #(.IPC(IPC), .OPC(OPC)) u_chain (
      .tck(tck), .rst_n(rst_sync_n), .test_act(test_act), .sel_int(sel_int),
      .sel_ext(sel_ext), .sel_byp(sel_byp), .shift(shift_en),
      .rail_si(rail_in[i]), .rail_so(rail_out[i]),
      .func_in(func_in[i*IPC +: IPC]), .core_in(core_in[i*IPC +: IPC]),
      .core_out(core_out[i*OPC +: OPC]), .func_out(func_out[i*OPC +: OPC]),
      .core_si(core_si[i]), .core_so(core_so[i])
    );
  end

  p_func_quiet_r1: assert property (@(posedge tck) disable iff (!rst_sync_n)
    (mode == 2'b00) |-> (rail_out == '0))
    else $error("rail active in functional mode");
  p_bypass_r4: assert property (@(posedge tck) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && mode == 2'b11 && $past(mode) == 2'b11)
      |-> (rail_out == $past(rail_in)))
    else $error("bypass lane is not one cycle");
  p_se_r3: assert property (@(posedge tck) disable iff (!rst_sync_n)
    (mode != 2'b01) |-> !core_se)
    else $error("core scan enable outside internal test");
endmodule

// File: tb/core_test_wrapper_tb_top.sv
`timescale 1ns/1ps
module core_test_wrapper_tb_top;
  localparam int RW = 3, IPC = 2, OPC = 2, CORE_LEN = 5;
  localparam int NI = RW*IPC, NO = RW*OPC;
  localparam logic [7:0] CONT = 8'b11101000;

  logic tck = 1'b0, rst_n = 1'b0, shift_en = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [RW-1:0] rail_in = '0, rail_out, core_si, core_so;
  logic [NI-1:0] func_in = '0, core_in;
  logic [NO-1:0] core_out, func_out;
  logic core_tck, core_se;

  int checks = 0, errors = 0, ctk_edges = 0, edges = 0, chain_n = 1;
  bit mon_on = 0, done = 0;
  logic [RW-1:0] exp_q[$];

  always #2 tck = ~tck;

  core_test_wrapper #(.RAIL_W(RW), .IN_PER_RAIL(IPC), .OUT_PER_RAIL(OPC)) dut_i (
    .tck(tck), .rst_n(rst_n), .mode(mode), .shift_en(shift_en),
    .rail_in(rail_in), .rail_out(rail_out), .func_in(func_in), .core_in(core_in),
    .core_out(core_out), .func_out(func_out), .core_tck(core_tck), .core_se(core_se),
    .core_si(core_si), .core_so(core_so)
  );

  // stub core: inverting combinational path plus one scan chain per lane
  logic [CORE_LEN-1:0] cchain [RW];
  assign core_out = ~core_in;
  for (genvar i = 0; i < RW; i++) begin : g_core
    always @(posedge core_tck or negedge rst_n)
      if (!rst_n) cchain[i] <= '0;
      else if (core_se) cchain[i] <= {cchain[i][CORE_LEN-2:0], core_si[i]};
    assign core_so[i] = cchain[i][CORE_LEN-1];
  end
  always @(posedge core_tck) ctk_edges++;
  always @(posedge tck) if (mon_on) edges++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(); @(posedge tck); #1; endtask

  function automatic logic [RW-1:0] cont_vec(input int k);
    logic [RW-1:0] v;
    v[0] = CONT[7 - (k % 8)];
    v[1] = ~CONT[7 - (k % 8)];
    v[2] = CONT[7 - ((k + 3) % 8)];
    return v;
  endfunction

  // scoreboard monitor: nothing before the lane length, then the queue in order
  always @(negedge tck) begin
    if (mon_on && edges > 0) begin
      if (edges >= chain_n && exp_q.size() > 0) begin
        logic [RW-1:0] e;
        e = exp_q.pop_front();
        chk(rail_out === e, "R4/R5/R6 lane data", 32'(rail_out), 32'(e));
      end else if (edges < chain_n) begin
        chk(rail_out === '0, "R4/R5/R6 no early arrival", 32'(rail_out), 0);
      end
    end
  end

  task automatic flush(input int n);
    rail_in = '0; shift_en = 1'b1;
    repeat (n) tick();
  endtask

  // driver: pushes each continuity vector as it is driven
  task automatic continuity(input int n);
    chain_n = n;
    edges = 0; mon_on = 1;
    for (int k = 0; k < 8; k++) begin
      rail_in = cont_vec(k);
      exp_q.push_back(cont_vec(k));
      tick();
    end
    rail_in = '0;
    repeat (n) tick();
    mon_on = 0;
    chk(exp_q.size() == 0, "R4/R5/R6 queue drained", 32'(exp_q.size()), 0);
  endtask

  initial begin
    repeat (12000) @(posedge tck);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ctk0;
    logic [NI-1:0] ci_pre;
    logic [RW-1:0] pv [9];
    func_in = 6'b101101;
    repeat (3) tick();
    // R9 reset state
    chk(rail_out === '0, "R9 rail_out in reset", 32'(rail_out), 0);
    chk(core_in === func_in, "R9 core_in in reset", 32'(core_in), 32'(func_in));
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 functional transparency, R2/R3 no test clock, no scan enable
    ctk0 = ctk_edges;
    shift_en = 1'b1; rail_in = '1;
    for (int k = 0; k < 4; k++) begin
      func_in = NI'(k * 13 + 5);
      tick();
      chk(core_in === func_in, "R1 core_in follows func_in", 32'(core_in), 32'(func_in));
      chk(func_out === core_out, "R1 func_out follows core_out", 32'(func_out), 32'(core_out));
      chk(rail_out === '0, "R1 rail_out zero", 32'(rail_out), 0);
      chk(core_se === 1'b0, "R3 no scan enable in functional", 32'(core_se), 0);
    end
    chk(ctk_edges == ctk0, "R2 no core clock in functional", 32'(ctk_edges - ctk0), 0);

    // R4 bypass
    mode = 2'b11; flush(3);
    continuity(1);
    chk(ctk_edges == ctk0, "R2 no core clock in bypass", 32'(ctk_edges - ctk0), 0);

    // R5 external test chain length
    mode = 2'b10;
    tick();
    chk(func_out === '0, "R9 holds cleared after reset", 32'(func_out), 0);
    flush(6);
    continuity(IPC + OPC);
    chk(core_se === 1'b0, "R3 no scan enable in external test", 32'(core_se), 0);

    // R7/R8 external capture and update
    func_in = 6'b110010;
    for (int k = 0; k < 4; k++) begin pv[k] = RW'(k * 3 + 2); rail_in = pv[k]; tick(); end
    shift_en = 1'b0; tick();
    for (int i = 0; i < RW; i++) begin
      chk(func_out[i*OPC+0] === pv[1][i], "R7 out cell 0 update", 32'(func_out[i*OPC+0]), 32'(pv[1][i]));
      chk(func_out[i*OPC+1] === pv[0][i], "R7 out cell 1 update", 32'(func_out[i*OPC+1]), 32'(pv[0][i]));
      chk(rail_out[i] === ~func_in[i*IPC+1], "R8 out cell 1 captured first", 32'(rail_out[i]), 32'(~func_in[i*IPC+1]));
    end
    shift_en = 1'b1; tick();
    for (int i = 0; i < RW; i++)
      chk(rail_out[i] === ~func_in[i*IPC+0], "R8 out cell 0 capture", 32'(rail_out[i]), 32'(~func_in[i*IPC+0]));
    tick();
    for (int i = 0; i < RW; i++)
      chk(rail_out[i] === func_in[i*IPC+1], "R8 in cell 1 captured func_in", 32'(rail_out[i]), 32'(func_in[i*IPC+1]));
    tick();
    for (int i = 0; i < RW; i++)
      chk(rail_out[i] === func_in[i*IPC+0], "R8 in cell 0 captured func_in", 32'(rail_out[i]), 32'(func_in[i*IPC+0]));
    for (int i = 0; i < RW; i++)
      chk(func_out[i*OPC +: OPC] === {pv[0][i], pv[1][i]}, "R7 hold frozen during shift",
          32'(func_out[i*OPC +: OPC]), 32'({pv[0][i], pv[1][i]}));
    chk(ctk_edges == ctk0, "R2 no core clock in external test", 32'(ctk_edges - ctk0), 0);

    // R6 internal test through core chain
    mode = 2'b01; flush(IPC + CORE_LEN + OPC + 3);
    chk(core_se === 1'b1, "R3 scan enable follows shift_en", 32'(core_se), 1);
    chk(ctk_edges > ctk0, "R2 core clock runs in internal test", 32'(ctk_edges - ctk0), 1);
    continuity(IPC + CORE_LEN + OPC);

    // R7/R8 internal apply and observe
    for (int k = 0; k < 9; k++) begin pv[k] = RW'(k * 5 + 1); rail_in = pv[k]; tick(); end
    ci_pre = core_in;
    shift_en = 1'b0;
    #0;
    chk(core_se === 1'b0, "R3 scan enable low on capture", 32'(core_se), 0);
    tick();
    for (int i = 0; i < RW; i++) begin
      chk(core_in[i*IPC+0] === pv[8][i], "R7 in cell 0 drives core", 32'(core_in[i*IPC+0]), 32'(pv[8][i]));
      chk(core_in[i*IPC+1] === pv[7][i], "R7 in cell 1 drives core", 32'(core_in[i*IPC+1]), 32'(pv[7][i]));
      chk(rail_out[i] === ~ci_pre[i*IPC+1], "R8 core output observed", 32'(rail_out[i]), 32'(~ci_pre[i*IPC+1]));
    end

    // R1 return to functional
    mode = 2'b00; shift_en = 1'b1; tick();
    chk(rail_out === '0, "R1 rail_out zero after test", 32'(rail_out), 0);
    chk(core_in === func_in, "R1 transparency restored", 32'(core_in), 32'(func_in));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule